// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Command Sequencer

This block owns the SDRAM command pins from reset until the memory is usable, and then keeps the memory refreshed. After reset it holds the command bus idle for the power-up pause, with clock enable and every data mask line high. It then closes all banks, runs a set of auto-refresh cycles and loads the mode register from three configuration inputs. Each wait between these commands is a clock count that the block derives from a nanosecond figure and the clock period, with any fraction rounded up to a whole cycle.

Once the mode load has settled, the block raises `init_done` and starts a refresh interval timer. Each time an interval expires, one refresh is owed. The block asks for a command slot on `refresh_req`. It issues the auto-refresh on the clock edge where both `refresh_req` and `refresh_grant` are high. Intervals that pass without a grant are stored in a small backlog counter, so refreshes are deferred but not dropped, up to a fixed limit. `refresh_req`/`refresh_grant` forms a plain request/grant pair and not a data stream. The request stays asserted until it is granted, and a grant given while no request is present has no effect.

Top module: `sdr_boot_refresh`

## Requirements
- R1: After reset is released, the command bus shows NOP (CS,RAS,CAS,WE = 0111) for PWR-1 cycles, where PWR = ceil(T_POWERUP_NS·1000 / CLK_PERIOD_PS). The first command appears after rising edge PWR. During the whole start-up phase CKE is 1 and every DQM bit is 1.
- R2: The first command is precharge-all (0010). It has address bit 10 set, all other address bits 0, and bank address 0.
- R3: The precharge is followed, after ceil(T_RP_NS·1000/CLK_PERIOD_PS) edges, by N_INIT_REF auto-refresh commands (0001). Consecutive refreshes are ceil(T_RFC_NS·1000/CLK_PERIOD_PS) edges apart, and only NOP appears in between.
- R4: One refresh spacing after the last start-up refresh, a mode load (0000) is issued. Its address carries the burst length code in bits 2:0 (0=1, 1=2, 2=4, 3=8), interleave in bit 3 (1=interleave), CAS latency in bits 6:4, and zero in every other bit.
- R5: After the mode load, only NOP appears for TMRD-1 cycles. `init_done` rises at edge TMRD after the mode load.
- R6: `refresh_req` is low before `init_done`. It first rises REFI = ceil(T_REFI_NS·1000/CLK_PERIOD_PS) edges after `init_done` rises. `init_done` never falls once it has risen.
- R7: An auto-refresh is issued on the edge where `refresh_req` and `refresh_grant` are both high, and `refresh_req` is low after that edge. While a backlog remains and the grant stays high, refreshes are T_RFC cycles apart.
- R8: An interval that expires without a grant stays owed and `refresh_req` stays high. Up to MAX_PEND owed refreshes are kept, and any beyond that are dropped.
- R9: After `init_done`, DQM is 0 and CKE is 1. During refresh and NOP the address and bank address are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cas_lat | input | 3 | CAS latency written by the mode load |
| cfg_interleave | input | 1 | 1 selects interleaved burst order |
| cfg_burst_code | input | 2 | Burst length code (0..3 for 1,2,4,8) |
| refresh_grant | input | 1 | Arbiter grant for a refresh slot |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_cke | output | 1 | Clock enable |
| sd_dqm | output | DQM_W | Data mask lines |
| sd_addr | output | ADDR_W | Address bus |
| sd_ba | output | BA_W | Bank address |
| init_done | output | 1 | Device is initialised and ready |
| refresh_req | output | 1 | A refresh slot is wanted |

## Verification
All command pins are registered. A command decided at edge N is therefore visible from edge N onward, and the bench samples one time unit after each rising edge. The start-up commands must appear exactly PWR, T_RP and T_RFC edges apart, and the mode load T_RFC edges after the last start-up refresh. `init_done` is due TMRD edges after the mode load and the first `refresh_req` REFI edges after that. The bench counts edges in these same units and checks that every intermediate cycle is NOP. A grant driven between edges produces the refresh command at the next edge, with `refresh_req` low in the same sample. The backlog is checked by counting refreshes within a window shorter than one interval.

// File: rtl/sdr_pkg.sv
package sdr_pkg;

  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sdr_cmd_e;

  typedef enum logic [2:0] {
    ST_PWR,
    ST_REF,
    ST_LMR,
    ST_GO,
    ST_RUN
  } seq_st_e;

  // nanoseconds to whole clock cycles, fractions rounded up
  function automatic int unsigned ns_to_cyc(input int unsigned ns,
                                            input int unsigned period_ps);
    return (ns * 1000 + period_ps - 1) / period_ps;
  endfunction

endpackage

// File: rtl/sdr_wait_timer.sv
module sdr_wait_timer #(
  parameter int unsigned W       = 8,
  parameter int unsigned RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= W'(RST_VAL);
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/sdr_refresh_pacer.sv
module sdr_refresh_pacer #(
  parameter int unsigned REFI_CYC = 1954,
  parameter int unsigned MAX_PEND = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic take,
  output logic owed
);
  localparam int unsigned IW = (REFI_CYC > 2) ? $clog2(REFI_CYC) : 1;
  localparam int unsigned PW = $clog2(MAX_PEND + 1);

  logic [IW-1:0] ivl;
  logic [PW-1:0] pend;
  logic          tick;

  assign tick = en && (ivl == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               ivl <= IW'(REFI_CYC - 1);
    else if (!en || tick)     ivl <= IW'(REFI_CYC - 1);
    else                      ivl <= ivl - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else begin
      case ({tick, take})
        2'b10:   if (pend != PW'(MAX_PEND)) pend <= pend + 1'b1;
        2'b01:   if (pend != '0)            pend <= pend - 1'b1;
        default: pend <= pend;
      endcase
    end
  end

  assign owed = (pend != '0);
endmodule

// File: rtl/sdr_boot_refresh.sv
module sdr_boot_refresh #(
  parameter int unsigned CLK_PERIOD_PS = 8000,
  parameter int unsigned T_POWERUP_NS  = 200000,
  parameter int unsigned T_RP_NS       = 20,
  parameter int unsigned T_RFC_NS      = 70,
  parameter int unsigned T_REFI_NS     = 15625,
  parameter int unsigned TMRD          = 2,
  parameter int unsigned N_INIT_REF    = 8,
  parameter int unsigned MAX_PEND      = 8,
  parameter int unsigned ADDR_W        = 12,
  parameter int unsigned BA_W          = 2,
  parameter int unsigned DQM_W         = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_cas_lat,
  input  logic              cfg_interleave,
  input  logic [1:0]        cfg_burst_code,
  input  logic              refresh_grant,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic              sd_cke,
  output logic [DQM_W-1:0]  sd_dqm,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [BA_W-1:0]   sd_ba,
  output logic              init_done,
  output logic              refresh_req
);
  import sdr_pkg::*;

  localparam int unsigned PWR_CYC  = ns_to_cyc(T_POWERUP_NS, CLK_PERIOD_PS);
  localparam int unsigned TRP_CYC  = ns_to_cyc(T_RP_NS, CLK_PERIOD_PS);
  localparam int unsigned TRFC_CYC = ns_to_cyc(T_RFC_NS, CLK_PERIOD_PS);
  localparam int unsigned REFI_CYC = ns_to_cyc(T_REFI_NS, CLK_PERIOD_PS);
  localparam int unsigned MAX_A    = (PWR_CYC > TRFC_CYC) ? PWR_CYC : TRFC_CYC;
  localparam int unsigned MAX_B    = (TRP_CYC > TMRD) ? TRP_CYC : TMRD;
  localparam int unsigned MAX_W    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned TW       = $clog2(MAX_W + 1);
  localparam int unsigned RLW      = $clog2(N_INIT_REF + 1);

  seq_st_e           st_q, st_n;
  logic [RLW-1:0]    left_q, left_n;
  sdr_cmd_e          cmd_q, cmd_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic              ready_q, ready_n;
  logic              t_load, t_done, owed, take;
  logic [TW-1:0]     t_val;

  sdr_wait_timer #(.W(TW), .RST_VAL(PWR_CYC - 1)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .done(t_done)
  );

  sdr_refresh_pacer #(.REFI_CYC(REFI_CYC), .MAX_PEND(MAX_PEND)) u_pacer (
    .clk(clk), .rst_n(rst_n), .en(ready_q), .take(take), .owed(owed)
  );

  assign refresh_req = (st_q == ST_RUN) && t_done && owed;

  always_comb begin
    st_n    = st_q;
    left_n  = left_q;
    cmd_n   = CMD_NOP;
    addr_n  = '0;
    ready_n = ready_q;
    t_load  = 1'b0;
    t_val   = '0;
    take    = 1'b0;
    if (t_done) begin
      unique case (st_q)
        ST_PWR: begin
          cmd_n      = CMD_PRE;
          addr_n[10] = 1'b1;
          t_load     = 1'b1;
          t_val      = TW'(TRP_CYC - 1);
          st_n       = ST_REF;
        end
        ST_REF: begin
          cmd_n  = CMD_REF;
          t_load = 1'b1;
          t_val  = TW'(TRFC_CYC - 1);
          left_n = left_q - 1'b1;
          if (left_q == RLW'(1)) st_n = ST_LMR;
        end
        ST_LMR: begin
          cmd_n       = CMD_LMR;
          addr_n[2:0] = {1'b0, cfg_burst_code};
          addr_n[3]   = cfg_interleave;
          addr_n[6:4] = cfg_cas_lat;
          t_load      = 1'b1;
          t_val       = TW'(TMRD - 1);
          st_n        = ST_GO;
        end
        ST_GO: begin
          ready_n = 1'b1;
          st_n    = ST_RUN;
        end
        ST_RUN: begin
          if (owed && refresh_grant) begin
            cmd_n  = CMD_REF;
            t_load = 1'b1;
            t_val  = TW'(TRFC_CYC - 1);
            take   = 1'b1;
          end
        end
        default: st_n = ST_PWR;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_PWR;
      left_q  <= RLW'(N_INIT_REF);
      cmd_q   <= CMD_NOP;
      addr_q  <= '0;
      ready_q <= 1'b0;
    end else begin
      st_q    <= st_n;
      left_q  <= left_n;
      cmd_q   <= cmd_n;
      addr_q  <= addr_n;
      ready_q <= ready_n;
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_addr   = addr_q;
  assign sd_ba     = '0;
  assign sd_cke    = 1'b1;
  assign sd_dqm    = {DQM_W{~ready_q}};
  assign init_done = ready_q;
endmodule

// File: rtl/sdr_boot_refresh_chk.sv
module sdr_boot_refresh_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned BA_W   = 2,
  parameter int unsigned DQM_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              refresh_grant,
  input logic              sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic              sd_cke,
  input logic [DQM_W-1:0]  sd_dqm,
  input logic [ADDR_W-1:0] sd_addr,
  input logic [BA_W-1:0]   sd_ba,
  input logic              init_done,
  input logic              refresh_req
);
  logic [3:0] cmd;
  assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  AST_BOOT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> (sd_cke && (&sd_dqm))); // R1

  AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0010) |-> (sd_addr[10] && sd_ba == '0)); // R2

  AST_MODE_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd) == 4'b0000) |-> (cmd == 4'b0111)); // R5

  AST_NO_EARLY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !refresh_req); // R6

  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done); // R6

  AST_REF_ON_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && cmd == 4'b0001) |-> $past(refresh_req && refresh_grant)); // R7

  AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_req && refresh_grant) |=> !refresh_req); // R7

  AST_RUN_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (sd_cke && sd_dqm == '0)); // R9
endmodule

bind sdr_boot_refresh sdr_boot_refresh_chk #(
  .ADDR_W(ADDR_W), .BA_W(BA_W), .DQM_W(DQM_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .refresh_grant(refresh_grant),
  .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
  .sd_we_n(sd_we_n), .sd_cke(sd_cke), .sd_dqm(sd_dqm),
  .sd_addr(sd_addr), .sd_ba(sd_ba), .init_done(init_done),
  .refresh_req(refresh_req)
);

// File: tb/tb_sdr_boot_refresh.sv
module tb_sdr_boot_refresh;
  localparam int PERIOD_PS = 8000;
  localparam int PWR_NS = 400, RP_NS = 20, RFC_NS = 70, REFI_NS = 2000;
  localparam int MRD = 2, NREF = 8, MAXP = 8;
  // expected cycle counts, ceiling of ns*1000/period
  localparam int E_PWR  = (PWR_NS  * 1000 + PERIOD_PS - 1) / PERIOD_PS;
  localparam int E_RP   = (RP_NS   * 1000 + PERIOD_PS - 1) / PERIOD_PS;
  localparam int E_RFC  = (RFC_NS  * 1000 + PERIOD_PS - 1) / PERIOD_PS;
  localparam int E_REFI = (REFI_NS * 1000 + PERIOD_PS - 1) / PERIOD_PS;
  localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, LMR = 4'b0000;

  logic clk = 0, rst_n = 0, grant = 0, ilv = 1;
  logic [2:0] cl = 3'd3;
  logic [1:0] bl = 2'd3;
  logic cs_n, ras_n, cas_n, we_n, cke, done, req;
  logic [7:0] dqm;
  logic [11:0] addr;
  logic [1:0] ba;
  logic [3:0] cmd;
  int checks = 0, fails = 0;
  bit finished = 0;

  assign cmd = {cs_n, ras_n, cas_n, we_n};
  always #4ns clk = ~clk;

  sdr_boot_refresh #(
    .CLK_PERIOD_PS(PERIOD_PS), .T_POWERUP_NS(PWR_NS), .T_RP_NS(RP_NS),
    .T_RFC_NS(RFC_NS), .T_REFI_NS(REFI_NS), .TMRD(MRD),
    .N_INIT_REF(NREF), .MAX_PEND(MAXP)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cfg_cas_lat(cl), .cfg_interleave(ilv),
    .cfg_burst_code(bl), .refresh_grant(grant), .sd_cs_n(cs_n),
    .sd_ras_n(ras_n), .sd_cas_n(cas_n), .sd_we_n(we_n), .sd_cke(cke),
    .sd_dqm(dqm), .sd_addr(addr), .sd_ba(ba), .init_done(done),
    .refresh_req(req)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1ns;
  endtask

  // n edges: NOP with masks held on the first n-1, command exp on the n-th
  task automatic expect_after(input int n, input logic [3:0] exp, input string tag);
    int bad = 0;
    for (int i = 1; i < n; i++) begin
      step();
      if (cmd != NOP || !cke || dqm != 8'hFF) bad++;
    end
    step();
    chk(bad == 0, {tag, " gap NOP/mask"}, bad, 0);
    chk(cmd == exp, {tag, " command"}, cmd, exp);
  endtask

  task automatic t_reset();
    #20ns;
    chk(cmd == NOP && cke && dqm == 8'hFF, "R1 reset state", {cmd, cke}, {NOP, 1'b1});
    chk(!done && !req, "R6 reset flags", {done, req}, 0);
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic t_boot();
    expect_after(E_PWR, PRE, "R1 power-up pause");
    chk(addr == 12'h400 && ba == 0, "R2 precharge-all address", addr, 12'h400);
    expect_after(E_RP, REF, "R3 first refresh");
    chk(addr == 0, "R9 refresh address", addr, 0);
    for (int i = 1; i < NREF; i++) expect_after(E_RFC, REF, "R3 start-up refresh");
    expect_after(E_RFC, LMR, "R4 mode load");
    chk(addr == 12'h03B, "R4 mode address", addr, 12'h03B);
    for (int i = 1; i < MRD; i++) begin
      step();
      chk(cmd == NOP && !done, "R5 mode settle", {cmd, done}, {NOP, 1'b0});
    end
    step();
    chk(done == 1, "R5 ready rise", done, 1);
    chk(dqm == 0 && cke, "R9 masks after ready", dqm, 0);
  endtask

  task automatic t_interval();
    int early = 0;
    for (int i = 1; i < E_REFI; i++) begin
      step();
      if (req || cmd != NOP) early++;
    end
    chk(early == 0, "R6 no request before interval", early, 0);
    step();
    chk(req == 1, "R6 request at interval", req, 1);
  endtask

  task automatic t_backlog();
    int refs = 0, last = -1, badgap = 0, lowgap = 0;
    for (int i = 0; i < 9 * E_REFI; i++) begin
      step();
      if (!req) lowgap++;
    end
    chk(lowgap == 0, "R8 request held while ungranted", lowgap, 0);
    step();
    grant = 1;
    for (int i = 0; i < 200; i++) begin
      step();
      if (cmd == REF) begin
        if (last >= 0 && i - last != E_RFC) badgap++;
        last = i;
        refs++;
      end
    end
    chk(refs == MAXP, "R8 backlog saturates", refs, MAXP);
    chk(badgap == 0, "R7 backlog spacing", badgap, 0);
    chk(req == 0, "R7 request cleared", req, 0);
  endtask

  task automatic t_granted();
    int waited = 0;
    while (!req && waited < 60) begin
      step();
      waited++;
    end
    chk(waited == 49, "R6 periodic interval", waited, 49);
    chk(cmd == NOP, "R7 no command before grant edge", cmd, NOP);
    step();
    chk(cmd == REF && !req, "R7 granted refresh", {cmd, req}, {REF, 1'b0});
    step();
    chk(cmd == NOP && done, "R6 ready kept", {cmd, done}, {NOP, 1'b1});
  endtask

  initial begin
    t_reset();
    t_boot();
    t_interval();
    t_backlog();
    t_granted();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule